// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two WIDTH-bit operands one bit per clock, using one full adder and one carry flip-flop. Both operands are first loaded in parallel into two right-shifting registers. After a start pulse, each clock feeds the lowest bit of each operand and the stored carry into the full adder. The full adder's carry-out is stored for the next clock. Its sum bit enters the top of the first operand register, so that register holds the sum once the addition completes. The carry left behind is the overflow of the addition.

The second operand register takes its top bit from a serial-in pin or from its own lowest bit, chosen by a select input. When it takes its own lowest bit, the operand is still intact after an addition, so it can be accumulated again without a reload. A busy flag covers the shift cycles. A one-cycle done pulse marks the clock in which the result appears.

Top module: `bit_serial_adder`

## Requirements
- R1: While rst_n is low, sum_out, carry_out, busy and done are all 0.
- R2: A clock edge with load=1 copies a_in into the result register and b_in into the second operand register, and clears carry_out, busy and done. Load wins over start and over an addition in progress, which it aborts.
- R3: A clock edge with start=1, load=0 and busy=0 sets busy and clears carry_out.
- R4: On each edge while busy=1 and load=0, the result register shifts right by one. Its new top bit is the XOR of its old bit 0, the second operand's bit 0 and carry_out. carry_out takes the majority of those three bits.
- R5: On each shift, the second operand register takes as its new top bit either its own old bit 0 (b_recirc=1) or b_ser_in (b_recirc=0).
- R6: Exactly WIDTH shift edges after busy rises, busy falls and done is 1 for one cycle. At that point sum_out equals (A+B) mod 2^WIDTH and carry_out equals bit WIDTH of A+B.
- R7: start has no effect while busy=1: the addition in progress still completes on its original schedule.
- R8: With busy=0, load=0 and start=0, sum_out and carry_out hold their values.
- R9: done and busy are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel load of both operands |
| a_in | input | WIDTH | First operand, parallel data |
| b_in | input | WIDTH | Second operand, parallel data |
| start | input | 1 | Begin an addition |
| b_recirc | input | 1 | 1: second operand recirculates; 0: takes b_ser_in |
| b_ser_in | input | 1 | Serial fill bit for the second operand |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum_out | output | WIDTH | Result register (first operand / sum) |
| carry_out | output | 1 | Carry flip-flop |

## Verification
A load is visible on sum_out one edge after it is applied. An accepted start raises busy on that same edge. The first sum bit enters the register one edge later, and the finished sum and done appear WIDTH edges after busy rises. The bench keeps a behavioural model that applies these latencies edge by edge. It compares every output with the model in the middle of every clock period, away from both edges. On top of that, it checks the finished sum arithmetically at the done cycle and checks that done has cleared one cycle later. Repeated additions without a reload expose the second operand's fill mode through the sum, because that register has no port of its own.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic [1:0] {
      BSA_HOLD  = 2'd0,
      BSA_LOAD  = 2'd1,
      BSA_SHIFT = 2'd2
   } bsa_op_e;
endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder #(
   parameter int STYLE = 0
) (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   generate
      if (STYLE == 0) begin : g_gates
         logic p;
         assign p  = x ^ y;
         assign s  = p ^ ci;
         assign co = (x & y) | (p & ci);
      end else if (STYLE == 1) begin : g_arith
         logic [1:0] t;
         assign t  = {1'b0, x} + {1'b0, y} + {1'b0, ci};
         assign s  = t[0];
         assign co = t[1];
      end else begin : g_bad
         $error("bsa_full_adder: STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg
   import bsa_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bsa_op_e          op,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (op == BSA_LOAD)   q <= par_in;
      else if (op == BSA_SHIFT)  q <= {ser_in, q[WIDTH-1:1]};
   end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
   import bsa_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic    start,
   output bsa_op_e op,
   output logic    carry_clr,
   output logic    busy,
   output logic    done
);
   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] cnt;
   logic          accept;
   logic          last_bit;

   assign accept    = start && !busy && !load;
   assign last_bit  = busy && (cnt == LAST);
   assign carry_clr = load || accept;

   always_comb begin
      if (load)      op = BSA_LOAD;
      else if (busy) op = BSA_SHIFT;
      else           op = BSA_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (load) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (busy) begin
         cnt  <= last_bit ? '0 : cnt + 1'b1;
         busy <= !last_bit;
         done <= last_bit;
      end else begin
         cnt  <= '0;
         busy <= accept;
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
   import bsa_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int FA_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             start,
   input  logic             b_recirc,
   input  logic             b_ser_in,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out
);
   generate
      if (WIDTH < 2) begin : g_chk_width
         $error("bit_serial_adder: WIDTH must be at least 2");
      end
   endgenerate

   bsa_op_e          op;
   logic             carry_clr;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic             fa_s;
   logic             fa_co;
   logic             b_fill;
   logic             carry_q;

   bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .start     (start),
      .op        (op),
      .carry_clr (carry_clr),
      .busy      (busy),
      .done      (done)
   );

   bsa_full_adder #(.STYLE(FA_STYLE)) u_fa (
      .x  (a_q[0]),
      .y  (b_q[0]),
      .ci (carry_q),
      .s  (fa_s),
      .co (fa_co)
   );

   assign b_fill = b_recirc ? b_q[0] : b_ser_in;

   bsa_shreg #(.WIDTH(WIDTH)) u_reg_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .par_in (a_in),
      .ser_in (fa_s),
      .q      (a_q)
   );

   bsa_shreg #(.WIDTH(WIDTH)) u_reg_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .par_in (b_in),
      .ser_in (b_fill),
      .q      (b_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              carry_q <= 1'b0;
      else if (carry_clr)      carry_q <= 1'b0;
      else if (op == BSA_SHIFT) carry_q <= fa_co;
   end

   assign sum_out   = a_q;
   assign carry_out = carry_q;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [WIDTH-1:0] a_in,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] sum_out,
   input logic             carry_out
);
   p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sum_out == $past(a_in)) && !busy && !done && !carry_out);

   p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !load) |=> busy && !carry_out);

   p_shift_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> sum_out[WIDTH-2:0] == $past(sum_out[WIDTH-1:1]));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_end_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) ##1 !busy |-> done);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load && !start) |=> $stable(sum_out) && $stable(carry_out));

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));
endmodule

bind bit_serial_adder bsa_checker #(.WIDTH(WIDTH)) u_bsa_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .a_in      (a_in),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .sum_out   (sum_out),
   .carry_out (carry_out)
);

// File: tb/test_bit_serial_adder.sv
`timescale 1ns/1ps
module test_bit_serial_adder;
   localparam int W = 8;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         start = 1'b0;
   logic         b_recirc = 1'b1;
   logic         b_ser_in = 1'b0;
   logic         busy, done, carry_out;
   logic [W-1:0] sum_out;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   bit_serial_adder #(.WIDTH(W)) i_bit_serial_adder (
      .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
      .start(start), .b_recirc(b_recirc), .b_ser_in(b_ser_in),
      .busy(busy), .done(done), .sum_out(sum_out), .carry_out(carry_out)
   );

   // behavioural reference model
   int ma, mb, mc, mcnt;
   bit mbusy, mdone;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma = 0; mb = 0; mc = 0; mcnt = 0; mbusy = 0; mdone = 0;
      end else if (load) begin
         ma = a_in; mb = b_in; mc = 0; mcnt = 0; mbusy = 0; mdone = 0;
      end else if (mbusy) begin
         int s, tot, fill;
         tot = (ma & 1) + (mb & 1) + mc;
         s = tot & 1;
         fill = b_recirc ? (mb & 1) : int'(b_ser_in);
         ma = (ma >> 1) | (s << (W - 1));
         mb = (mb >> 1) | (fill << (W - 1));
         mc = tot >> 1;
         mcnt++;
         mdone = 0;
         if (mcnt == W) begin mbusy = 0; mdone = 1; end
      end else begin
         mdone = 0;
         if (start) begin mbusy = 1; mc = 0; mcnt = 0; end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R4, R5, R6, R9)
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(int'(sum_out) == ma, "R4 sum_out vs model", int'(sum_out), ma);
         check(int'(carry_out) == mc, "R4 carry_out vs model", int'(carry_out), mc);
         check(busy == mbusy, "R6 busy vs model", int'(busy), int'(mbusy));
         check(done == mdone, "R6 done vs model", int'(done), int'(mdone));
         check(!(busy && done), "R9 busy and done exclusive", int'({busy, done}), 1);
      end
   end

   task automatic do_load(input int a, input int b);
      @(negedge clk); load = 1'b1; a_in = W'(a); b_in = W'(b);
      @(negedge clk); load = 1'b0;
      check(int'(sum_out) == (a & MASK) && !busy && !carry_out, "R2 load", int'(sum_out), a & MASK);
   endtask

   task automatic run_add(input int exp_sum, input int exp_c, input string req);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1 && carry_out == 1'b0, "R3 start accepted", int'(busy), 1);
      repeat (W) @(negedge clk);
      check(done == 1'b1 && busy == 1'b0, {req, " done at WIDTH shifts"}, int'(done), 1);
      check(int'(sum_out) == exp_sum, {req, " sum"}, int'(sum_out), exp_sum);
      check(int'(carry_out) == exp_c, {req, " carry"}, int'(carry_out), exp_c);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(sum_out == '0 && !carry_out && !busy && !done, "R1 reset state", int'(sum_out), 0);
      rst_n = 1'b1;

      do_load(8'h5A, 8'h3C); run_add(8'h96, 0, "R6 5A+3C");
      do_load(8'hFF, 8'h01); run_add(8'h00, 1, "R6 FF+01");
      do_load(8'h80, 8'h80); run_add(8'h00, 1, "R6 80+80");
      do_load(8'h00, 8'h00); run_add(8'h00, 0, "R6 00+00");

      // R5 recirculation: B preserved, second add uses B again
      b_recirc = 1'b1;
      do_load(8'h11, 8'h22); run_add(8'h33, 0, "R5 recirc first");
      run_add(8'h55, 0, "R5 recirc second");
      // R5 serial fill with 0: B becomes zero
      b_recirc = 1'b0; b_ser_in = 1'b0;
      do_load(8'h40, 8'h07); run_add(8'h47, 0, "R5 zero fill first");
      run_add(8'h47, 0, "R5 zero fill second");
      // R5 serial fill with 1: B becomes all ones
      b_ser_in = 1'b1;
      do_load(8'h10, 8'h01); run_add(8'h11, 0, "R5 ones fill first");
      run_add(8'h10, 1, "R5 ones fill second");
      b_recirc = 1'b1; b_ser_in = 1'b0;

      // R7 start while busy is ignored
      do_load(8'h0F, 8'h01);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (W - 4) @(negedge clk);
      check(done == 1'b1 && int'(sum_out) == 8'h10, "R7 start ignored while busy", int'(sum_out), 8'h10);

      // R2 load aborts an addition in progress
      do_load(8'h33, 8'h44);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
      do_load(8'hA5, 8'h01);
      check(!busy && !done, "R2 load aborts", int'(busy), 0);

      // R2 load and start together: load wins
      @(negedge clk); load = 1'b1; start = 1'b1; a_in = 8'h66; b_in = 8'h01;
      @(negedge clk); load = 1'b0; start = 1'b0;
      check(!busy && int'(sum_out) == 8'h66, "R2 load over start", int'(busy), 0);

      // R8 idle hold
      repeat (5) @(negedge clk);
      check(int'(sum_out) == 8'h66 && !carry_out, "R8 idle hold", int'(sum_out), 8'h66);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cycles > 5000);
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule